// File: doc/BRIEF.md
# Capture Source Selector and Edge Prescaler

This block sits in front of the capture register of one timer channel. It picks the edge events that can trigger a capture from one of three candidates: the channel's own filtered input, the filtered input of the neighbouring channel, or an internal trigger line. A fourth selection code turns the channel into an output, and no capture is then possible. The active edges of the chosen source are counted, and a one-cycle capture strobe is issued once every 1, 2, 4 or 8 of them.

Configuration is held in three small registers: source selection, prescale code and channel enable. All three are loaded together through one write port. The selection can only change while the channel is disabled. Disabling the channel also clears the edge counter, so the next enable starts a fresh count. The current register values are brought out so that the owner of the channel can read them back. The counter being captured and the edge-polarity logic live elsewhere.

Top module: `capsel_prescaler`

## Requirements
- R1: With selection code 00 (output mode), the capture strobe never asserts, whatever the event inputs do.
- R2: Selection 01 counts pulses on `ev_own`, 10 counts pulses on `ev_nbr` and 11 counts pulses on `ev_trig`. The two unselected inputs have no effect.
- R3: Prescale code 00, 01, 10 or 11 issues one capture strobe per 1, 2, 4 or 8 counted events. The strobe is high for exactly one cycle, in the cycle after the clock edge at which the completing event is sampled.
- R4: The edge counter returns to zero on the edge that completes the count. The following events start a new group of the full ratio.
- R5: While the channel enable register is 0, no strobe is produced and the edge counter is held at zero. After a re-enable, a full group of events is needed before the next strobe.
- R6: A write leaves the selection register unchanged when the enable register is 1 at that edge. The prescale and enable fields of the same write still take effect.
- R7: With selection 11 and `trig_valid` low, trigger pulses are not counted and produce no strobe.
- R8: A new prescale code applies from the next counted event, and the count already reached is kept. If that count plus one reaches the new ratio, that event issues the strobe.
- R9: After reset, the selection and prescale registers read 00, the enable reads 0 and the strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_own | input | 1 | Edge-event pulse from the channel's own filtered input |
| ev_nbr | input | 1 | Edge-event pulse from the neighbouring channel's filtered input |
| ev_trig | input | 1 | Edge-event pulse from the internal trigger |
| trig_valid | input | 1 | High when an internal trigger input is selected upstream |
| wr_en | input | 1 | Load the configuration registers this cycle |
| wr_sel | input | 2 | Source selection value to write (00 output, 01 own, 10 neighbour, 11 trigger) |
| wr_psc | input | 2 | Prescale code to write (ratio 2**code) |
| wr_chan_en | input | 1 | Channel enable value to write |
| cap_strobe | output | 1 | One-cycle capture strobe |
| cur_sel | output | 2 | Current selection register |
| cur_psc | output | 2 | Current prescale register |
| cur_en | output | 1 | Current channel enable register |

## Verification
A wrong value in the edge counter does not show until the next group completes. The strobe then comes early or late, by up to seven events. Clearing on disable and keeping the count across a prescale change are therefore checked by counting the events up to the next strobe. A selection register that wrongly accepts a write while enabled shows on `cur_sel` in the very next cycle. A fault in the source routing shows as a missing or extra strobe on the first event, because the sweeps with ratio one make every counted event visible.

// File: rtl/capsel_pkg.sv
package capsel_pkg;

  localparam int SEL_W = 2;
  localparam int PSC_W = 2;
  // counter must hold up to (max ratio - 1) = 2**(2**PSC_W - 1) - 1
  localparam int CNT_W = (1 << PSC_W) - 1;

  typedef enum logic [SEL_W-1:0] {
    SRC_OUTPUT = 2'b00,
    SRC_OWN    = 2'b01,
    SRC_NEIGH  = 2'b10,
    SRC_TRIG   = 2'b11
  } src_sel_e;

  // number of counted events per capture for a prescale code
  function automatic logic [CNT_W:0] psc_ratio(input logic [PSC_W-1:0] code);
    logic [CNT_W:0] one;
    one = {{CNT_W{1'b0}}, 1'b1};
    return one << code;
  endfunction

  // true when one more event completes the group
  function automatic logic group_done(input logic [CNT_W-1:0] cnt,
                                      input logic [PSC_W-1:0] code);
    logic [CNT_W:0] nxt;
    nxt = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
    return nxt >= psc_ratio(code);
  endfunction

endpackage

// File: rtl/capsel_cfg_regs.sv
module capsel_cfg_regs
  import capsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PSC_W-1:0] wr_psc,
  input  logic             wr_chan_en,
  output src_sel_e         sel_q,
  output logic [PSC_W-1:0] psc_q,
  output logic             en_q
);

  logic sel_load;

  // selection is only writable while the channel is off
  assign sel_load = wr_en & ~en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SRC_OUTPUT;
      psc_q <= '0;
      en_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        psc_q <= wr_psc;
        en_q  <= wr_chan_en;
      end
      if (sel_load) begin
        sel_q <= src_sel_e'(wr_sel);
      end
    end
  end

endmodule

// File: rtl/capsel_src_mux.sv
module capsel_src_mux
  import capsel_pkg::*;
(
  input  logic     ev_own,
  input  logic     ev_nbr,
  input  logic     ev_trig,
  input  logic     trig_valid,
  input  src_sel_e sel,
  output logic     evt_sel
);

  localparam int NUM_CODES = 1 << SEL_W;

  logic [NUM_CODES-1:0] cand;

  // the output code never produces an event; the trigger needs a valid source
  assign cand[SRC_OUTPUT] = 1'b0;
  assign cand[SRC_OWN]    = ev_own;
  assign cand[SRC_NEIGH]  = ev_nbr;
  assign cand[SRC_TRIG]   = ev_trig & trig_valid;

  assign evt_sel = cand[sel];

endmodule

// File: rtl/capsel_edge_divider.sv
module capsel_edge_divider
  import capsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             evt,
  input  logic [PSC_W-1:0] psc,
  output logic             evt_hit,
  output logic [CNT_W-1:0] cnt_q,
  output logic             cap_strobe
);

  logic done;

  assign done    = group_done(cnt_q, psc);
  assign evt_hit = en & evt & done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      cap_strobe <= 1'b0;
    end else begin
      cap_strobe <= evt_hit;
      if (!en) begin
        cnt_q <= '0;
      end else if (evt) begin
        cnt_q <= done ? '0 : cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/capsel_prescaler.sv
module capsel_prescaler
  import capsel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_own,
  input  logic             ev_nbr,
  input  logic             ev_trig,
  input  logic             trig_valid,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [PSC_W-1:0] wr_psc,
  input  logic             wr_chan_en,
  output logic             cap_strobe,
  output logic [SEL_W-1:0] cur_sel,
  output logic [PSC_W-1:0] cur_psc,
  output logic             cur_en
);

  src_sel_e         sel_q;
  logic [PSC_W-1:0] psc_q;
  logic             en_q;
  logic             evt_sel;
  logic             evt_hit;
  logic [CNT_W-1:0] cnt_q;

  capsel_cfg_regs u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_psc     (wr_psc),
    .wr_chan_en (wr_chan_en),
    .sel_q      (sel_q),
    .psc_q      (psc_q),
    .en_q       (en_q)
  );

  capsel_src_mux u_mux (
    .ev_own     (ev_own),
    .ev_nbr     (ev_nbr),
    .ev_trig    (ev_trig),
    .trig_valid (trig_valid),
    .sel        (sel_q),
    .evt_sel    (evt_sel)
  );

  capsel_edge_divider u_div (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en_q),
    .evt        (evt_sel),
    .psc        (psc_q),
    .evt_hit    (evt_hit),
    .cnt_q      (cnt_q),
    .cap_strobe (cap_strobe)
  );

  assign cur_sel = sel_q;
  assign cur_psc = psc_q;
  assign cur_en  = en_q;

endmodule

// File: rtl/capsel_checker.sv
module capsel_checker
  import capsel_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             trig_valid,
  input logic [SEL_W-1:0] cur_sel,
  input logic [PSC_W-1:0] cur_psc,
  input logic             cur_en,
  input logic             evt_sel,
  input logic             evt_hit,
  input logic [CNT_W-1:0] cnt_q,
  input logic             cap_strobe
);

  AST_OUTPUT_MODE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_sel == 2'b00) |=> !cap_strobe); // R1

  AST_TRIG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_sel == 2'b11 && !trig_valid) |-> !evt_sel); // R7

  AST_EVERY_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_en && cur_psc == 2'b00 && evt_sel) |=> cap_strobe); // R3

  AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> $past(evt_hit)); // R3

  AST_WRAP_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |-> (cnt_q == '0)); // R4

  AST_DISABLED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cur_en |=> (cnt_q == '0 && !cap_strobe)); // R5

  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    cur_en |=> $stable(cur_sel)); // R6

endmodule

bind capsel_prescaler capsel_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .trig_valid (trig_valid),
  .cur_sel    (cur_sel),
  .cur_psc    (cur_psc),
  .cur_en     (cur_en),
  .evt_sel    (evt_sel),
  .evt_hit    (evt_hit),
  .cnt_q      (cnt_q),
  .cap_strobe (cap_strobe)
);

// File: tb/test_capsel_prescaler.sv
module test_capsel_prescaler;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_own = 0, ev_nbr = 0, ev_trig = 0, trig_valid = 0;
  logic       wr_en = 0, wr_chan_en = 0;
  logic [1:0] wr_sel = 0, wr_psc = 0;
  logic       cap_strobe, cur_en;
  logic [1:0] cur_sel, cur_psc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  // bench model of the configuration and the count
  int m_sel = 0, m_psc = 0, m_en = 0, m_cnt = 0;
  int m_strobe = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  capsel_prescaler i_capsel_prescaler (
    .clk(clk), .rst_n(rst_n),
    .ev_own(ev_own), .ev_nbr(ev_nbr), .ev_trig(ev_trig), .trig_valid(trig_valid),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_psc(wr_psc), .wr_chan_en(wr_chan_en),
    .cap_strobe(cap_strobe), .cur_sel(cur_sel), .cur_psc(cur_psc), .cur_en(cur_en)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // one clock cycle: drive after the falling edge, compare after the rising edge
  task automatic cyc(input bit o, input bit n, input bit t, input bit tv,
                     input bit w, input int ws, input int wp, input bit we,
                     input string tag);
    bit counted;
    int ratio;
    @(negedge clk);
    ev_own = o; ev_nbr = n; ev_trig = t; trig_valid = tv;
    wr_en = w; wr_sel = 2'(ws); wr_psc = 2'(wp); wr_chan_en = we;
    ratio = 2 ** m_psc;
    counted = (m_sel == 1 && o) || (m_sel == 2 && n) || (m_sel == 3 && t && tv);
    m_strobe = 0;
    if (m_en == 0) m_cnt = 0;
    else if (counted) begin
      if (m_cnt + 1 >= ratio) begin m_strobe = 1; m_cnt = 0; end
      else m_cnt = m_cnt + 1;
    end
    if (w) begin
      if (m_en == 0) m_sel = ws;
      m_psc = wp;
      m_en = we;
    end
    @(posedge clk);
    #1;
    check(tag, "strobe", int'(cap_strobe), m_strobe);
    check(tag, "sel", int'(cur_sel), m_sel);
    check(tag, "psc", int'(cur_psc), m_psc);
    check(tag, "en", int'(cur_en), m_en);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cfg(input int s, input int p, input bit e, input string tag);
    cyc(0, 0, 0, 0, 1, s, p, e, tag);
  endtask

  // counts events on own input until a strobe; returns the count
  task automatic events_to_strobe(input int limit, input string tag, output int got);
    got = 0;
    for (int k = 0; k < limit; k++) begin
      cyc(1, 0, 0, 0, 0, 0, 0, 0, tag);
      got++;
      if (cap_strobe) break;
    end
  endtask

  initial begin
    int got;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    // R9: reset values
    check("R9", "strobe", int'(cap_strobe), 0);
    check("R9", "sel", int'(cur_sel), 0);
    check("R9", "psc", int'(cur_psc), 0);
    check("R9", "en", int'(cur_en), 0);

    // sweep: every selection, trigger-valid and prescale, mixed event patterns
    for (int s = 0; s < 4; s++) begin
      for (int tv = 0; tv < 2; tv++) begin
        for (int p = 0; p < 4; p++) begin
          string tag;
          tag = (s == 0) ? "R1" : (s == 3 && tv == 0) ? "R7" : "R3";
          cfg(s, p, 0, tag);
          cfg(s, p, 1, tag);
          for (int i = 0; i < 40; i++) begin
            string ctag;
            ctag = (m_cnt == 0 && i > 0) ? "R4" : tag;
            cyc(i % 3 != 0, i % 2 == 0, i % 5 < 2, tv[0], 0, 0, 0, 0, ctag);
          end
          cfg(s, p, 0, tag);
        end
      end
    end

    // R2: a single source pulses at a time, ratio one
    for (int s = 1; s < 4; s++) begin
      cfg(s, 0, 1, "R2");
      cyc(1, 0, 0, 1, 0, 0, 0, 0, "R2");
      cyc(0, 1, 0, 1, 0, 0, 0, 0, "R2");
      cyc(0, 0, 1, 1, 0, 0, 0, 0, "R2");
      idle("R2");
      cfg(s, 0, 0, "R2");
    end

    // R6: selection write while enabled is dropped, other fields land
    cfg(1, 0, 1, "R6");
    cfg(2, 3, 1, "R6");
    check("R6", "sel kept", int'(cur_sel), 1);
    check("R6", "psc taken", int'(cur_psc), 3);
    cfg(3, 1, 0, "R6");
    check("R6", "sel kept on disabling write", int'(cur_sel), 1);
    cfg(2, 1, 0, "R6");
    check("R6", "sel written while off", int'(cur_sel), 2);

    // R5: partial count is discarded by a disable
    cfg(1, 2, 1, "R5");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    cyc(1, 0, 0, 0, 1, 1, 2, 0, "R5");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R5");
    cfg(1, 2, 1, "R5");
    events_to_strobe(10, "R5", got);
    check("R5", "events after re-enable", got, 4);

    // R8: count is kept when the ratio grows
    cfg(1, 2, 0, "R8");
    cfg(1, 2, 1, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cfg(1, 3, 1, "R8");
    events_to_strobe(12, "R8", got);
    check("R8", "events after ratio 4->8", got, 6);
    // R8: count already past the new smaller ratio fires at the next event
    for (int k = 0; k < 5; k++) cyc(1, 0, 0, 0, 0, 0, 0, 0, "R8");
    cfg(1, 1, 1, "R8");
    events_to_strobe(4, "R8", got);
    check("R8", "events after ratio 8->2", got, 1);
    events_to_strobe(4, "R4", got);
    check("R4", "full group after wrap", got, 2);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule